// File: doc/BRIEF.md
# Bit-Serial Constant Product Bank

This block takes one signed activation, delivered one bit per clock with the least significant bit first. From it, the block produces one serial product stream for each value that a quantized weight may hold, and it produces all of them at the same time. Each weight value is a fixed parameter. The multiplication by each value is built from a short shared delay line and chains of one-bit serial adders, each of which keeps its carry in a flip-flop. There is no general multiplier anywhere in the datapath. The product lines leave side by side as a bus, one lane per weight value, so that a downstream selection array can route whichever product each weight calls for. The activation is therefore multiplied by each constant only once, however many weights later use it.

A frame starts with a one-cycle start strobe that comes together with bit 0 of the activation. The frame then lasts the activation width plus a number of guard bits. During the guard cycles the block repeats the latched sign bit of the activation on its own, so the caller does not have to drive meaningful data there. The products appear one clock after their input bits. A valid line covers the whole output frame, and a done line marks the cycle that holds the final product bit.

Top module: `cprod_bank`

## Requirements
- R1: While reset is asserted, and after its release until a start strobe arrives, prodBitsOut is all zeros and prodBitValid and prodDone are low.
- R2: A frame is FRAME_LEN = ACT_W + GUARD cycles long (default 8 + 3 = 11). It begins in the cycle where startIn is high, which carries input bit 0, and input bit i is sampled i cycles later. Product bit i is presented on prodBitsOut in the cycle after input bit i is sampled. prodBitValid is high for exactly those FRAME_LEN output cycles.
- R3: Over one frame, lane j of prodBitsOut, read LSB first, is the FRAME_LEN-bit two's complement value of the activation times WEIGHT_SET[j]. The activation is signed ACT_W-bit two's complement. The default lanes are j=0: -3, j=1: -1, j=2: +1, j=3: +3.
- R4: For input indices ACT_W and above, actBitIn is ignored and the sign bit sampled at index ACT_W-1 is used in its place. Any level driven there leaves every lane's product unchanged.
- R5: prodDone is high only in the output cycle that holds product bit FRAME_LEN-1, and it is high once per completed frame.
- R6: A start strobe that arrives inside a frame abandons the old frame. The new frame starts from cleared carries and delays, produces correct products, and never raises prodDone for the abandoned frame.
- R7: A new start strobe may come in the cycle right after the last input bit of the previous frame. Both frames then produce correct products with no idle cycle between them.
- R8: Outside a frame, prodBitsOut is all zeros and prodBitValid is low, whatever level actBitIn has.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Frame start strobe, high together with activation bit 0 |
| actBitIn | input | 1 | Serial activation bit, LSB first |
| prodBitsOut | output | NUM_W | One serial product bit per weight value |
| prodBitValid | output | 1 | High while prodBitsOut carries a frame's bits |
| prodDone | output | 1 | High on the cycle carrying the final product bit |

## Verification
The assertions assume that startIn is a single-cycle strobe driven only in a frame's first cycle, and that every WEIGHT_SET magnitude fits in MAG_W bits, so that FRAME_LEN bits hold every product. The bench drives startIn for exactly one cycle per frame and uses the default weights, whose magnitudes are at most 3. It sweeps every 8-bit activation, placing frames back to back and changing the junk pattern on the guard cycles. It also cuts frames short in the middle, while carries are pending, to exercise the restart path.

// File: rtl/cprod_pkg.sv
package cprod_pkg;

  typedef struct packed {
    logic clear;     // first cycle of a frame: reset carries and delays
    logic live;      // an input bit is being consumed this cycle
    logic holdSign;  // current input bit is the activation MSB
    logic extend;    // guard cycle: use the held sign bit
    logic last;      // final bit of the frame
  } ctlStrobes_t;

  function automatic int unsigned magOf(input int signed w);
    return (w < 0) ? int'(-w) : int'(w);
  endfunction

endpackage

// File: rtl/cprod_ctrl.sv
module cprod_ctrl #(
  parameter int ACT_W     = 8,
  parameter int FRAME_LEN = 11
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   startIn,
  output cprod_pkg::ctlStrobes_t stb
);
  localparam int IDX_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;

  logic [IDX_W-1:0] cntQ;
  logic             busyQ;
  logic [IDX_W-1:0] idx;
  logic             live;

  assign idx  = startIn ? '0 : cntQ;
  assign live = startIn | busyQ;

  always_comb begin
    stb.clear    = startIn;
    stb.live     = live;
    stb.holdSign = live && (idx == IDX_W'(ACT_W - 1));
    stb.extend   = live && (idx >= IDX_W'(ACT_W));
    stb.last     = live && (idx == IDX_W'(FRAME_LEN - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ  <= '0;
      busyQ <= 1'b0;
    end else if (startIn) begin
      busyQ <= (FRAME_LEN > 1);
      cntQ  <= IDX_W'(1);
    end else if (busyQ) begin
      if (cntQ == IDX_W'(FRAME_LEN - 1)) begin
        busyQ <= 1'b0;
        cntQ  <= '0;
      end else begin
        cntQ <= cntQ + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/cprod_dpath.sv
module cprod_dpath #(
  parameter int        NUM_W = 4,
  parameter int        MAG_W = 2,
  parameter int signed WEIGHT_SET [NUM_W] = '{-3, -1, 1, 3}
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  cprod_pkg::ctlStrobes_t stb,
  input  logic                   actBitIn,
  output logic [NUM_W-1:0]       prodBitsOut,
  output logic                   prodBitValid,
  output logic                   prodDone
);
  logic             signQ;
  logic             effBit;
  logic [MAG_W-2:0] dlyQ;
  logic [MAG_W-1:0] tap;
  logic [NUM_W-1:0] laneBits;

  assign effBit = stb.extend ? signQ : actBitIn;

  always_ff @(posedge clk) begin
    if (!rstN) signQ <= 1'b0;
    else if (stb.holdSign) signQ <= actBitIn;
  end

  // shared delay line: tap[k] is the activation shifted left by k
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dlyQ <= '0;
    end else if (stb.live) begin
      dlyQ[0] <= effBit;
      for (int j = 1; j <= MAG_W - 2; j++) begin
        dlyQ[j] <= stb.clear ? 1'b0 : dlyQ[j-1];
      end
    end
  end

  assign tap[0] = effBit;
  for (genvar k = 1; k < MAG_W; k++) begin : g_tap
    assign tap[k] = stb.clear ? 1'b0 : dlyQ[k-1];
  end

  for (genvar l = 0; l < NUM_W; l++) begin : g_lane
    localparam int unsigned MAG = cprod_pkg::magOf(WEIGHT_SET[l]);
    localparam bit          NEG = (WEIGHT_SET[l] < 0);

    logic [MAG_W:0]   part;
    logic [MAG_W-1:0] carryQ;
    logic [MAG_W-1:0] carryNxt;
    logic             negQ;
    logic             negIn;
    logic             negCin;

    assign part[0] = 1'b0;
    for (genvar k = 0; k < MAG_W; k++) begin : g_add
      localparam bit USE = ((MAG >> k) & 1) == 1;
      logic addend;
      logic cin;
      assign addend      = USE ? tap[k] : 1'b0;
      assign cin         = stb.clear ? 1'b0 : carryQ[k];
      assign part[k+1]   = part[k] ^ addend ^ cin;
      assign carryNxt[k] = (part[k] & addend) | (cin & (part[k] ^ addend));
    end

    // serial two's complement negation: invert and add one
    assign negIn       = part[MAG_W] ^ NEG;
    assign negCin      = stb.clear ? NEG : negQ;
    assign laneBits[l] = negIn ^ negCin;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        carryQ <= '0;
        negQ   <= 1'b0;
      end else if (stb.live) begin
        carryQ <= carryNxt;
        negQ   <= negIn & negCin;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prodBitsOut  <= '0;
      prodBitValid <= 1'b0;
      prodDone     <= 1'b0;
    end else begin
      prodBitsOut  <= stb.live ? laneBits : '0;
      prodBitValid <= stb.live;
      prodDone     <= stb.last;
    end
  end
endmodule

// File: rtl/cprod_bank.sv
module cprod_bank #(
  parameter int        ACT_W = 8,
  parameter int        GUARD = 3,
  parameter int        NUM_W = 4,
  parameter int        MAG_W = 2,
  parameter int signed WEIGHT_SET [NUM_W] = '{-3, -1, 1, 3},
  localparam int       FRAME_LEN = ACT_W + GUARD
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic             actBitIn,
  output logic [NUM_W-1:0] prodBitsOut,
  output logic             prodBitValid,
  output logic             prodDone
);
  cprod_pkg::ctlStrobes_t stb;

  cprod_ctrl #(.ACT_W(ACT_W), .FRAME_LEN(FRAME_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .stb(stb)
  );

  cprod_dpath #(.NUM_W(NUM_W), .MAG_W(MAG_W), .WEIGHT_SET(WEIGHT_SET)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .actBitIn(actBitIn),
    .prodBitsOut(prodBitsOut), .prodBitValid(prodBitValid), .prodDone(prodDone)
  );
endmodule

// File: rtl/cprod_bank_chk.sv
module cprod_bank_chk #(
  parameter int FRAME_LEN = 11,
  parameter int NUM_W     = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             startIn,
  input logic [NUM_W-1:0] prodBitsOut,
  input logic             prodBitValid,
  input logic             prodDone
);
  localparam int CW = $clog2(FRAME_LEN + 2);

  // index of the output bit expected this cycle, 1-based; 0 when idle
  logic [CW-1:0] outCnt;

  always_ff @(posedge clk) begin
    if (!rstN) outCnt <= '0;
    else if (startIn) outCnt <= CW'(1);
    else if (outCnt != '0 && outCnt < CW'(FRAME_LEN)) outCnt <= outCnt + CW'(1);
    else outCnt <= '0;
  end

  AST_DONE_AT_LAST: assert property (@(posedge clk) disable iff (!rstN)
    prodDone |-> outCnt == CW'(FRAME_LEN)); // R5
  AST_VALID_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    (outCnt != '0) |-> prodBitValid); // R2
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rstN)
    prodBitValid |-> (outCnt != '0)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !prodBitValid |-> (prodBitsOut == '0)); // R8
  AST_DONE_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    prodDone |-> prodBitValid); // R5
endmodule

bind cprod_bank cprod_bank_chk #(.FRAME_LEN(FRAME_LEN), .NUM_W(NUM_W)) u_chk (
  .clk(clk), .rstN(rstN), .startIn(startIn), .prodBitsOut(prodBitsOut),
  .prodBitValid(prodBitValid), .prodDone(prodDone)
);

// File: tb/cprod_bank_tb.sv
module cprod_bank_tb;
  localparam int ACT_W = 8;
  localparam int GUARD = 3;
  localparam int NUM_W = 4;
  localparam int L     = ACT_W + GUARD;
  localparam int W_EXP [NUM_W] = '{-3, -1, 1, 3};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startIn = 1'b0;
  logic actBitIn = 1'b0;
  logic [NUM_W-1:0] prodBitsOut;
  logic prodBitValid, prodDone;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  cprod_bank u_dut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .actBitIn(actBitIn),
    .prodBitsOut(prodBitsOut), .prodBitValid(prodBitValid), .prodDone(prodDone)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic stepIn(input logic s, input logic b);
    @(negedge clk);
    startIn  = s;
    actBitIn = b;
    @(posedge clk);
    #1;
  endtask

  function automatic logic junkBit(input int mode, input int i, input logic sgn);
    case (mode)
      0: return sgn;
      1: return 1'b1;
      2: return 1'b0;
      default: return logic'(i & 1);
    endcase
  endfunction

  // runs nBits of a frame; when nBits==L the products are checked
  task automatic runFrame(input int a, input int mode, input int nBits, input string req);
    logic [L-1:0] cap [NUM_W];
    logic [ACT_W-1:0] av = ACT_W'(a);
    int validBad = 0;
    int doneBad = 0;
    for (int i = 0; i < nBits; i++) begin
      stepIn(i == 0, (i < ACT_W) ? av[i] : junkBit(mode, i, av[ACT_W-1]));
      for (int j = 0; j < NUM_W; j++) cap[j][i] = prodBitsOut[j];
      if (!prodBitValid) validBad++;
      if (prodDone != (i == L - 1)) doneBad++;
    end
    check(validBad == 0, "R2", "valid gaps in frame", validBad, 0);
    check(doneBad == 0, "R5", "done misplaced", doneBad, 0);
    if (nBits == L) begin
      for (int j = 0; j < NUM_W; j++) begin
        int expv = a * W_EXP[j];
        logic [L-1:0] expBits = L'(expv);
        check(cap[j] == expBits, req, $sformatf("lane %0d act %0d mode %0d", j, a, mode),
              int'($signed(cap[j])), expv);
      end
    end
  endtask

  task automatic idleCheck(input int n);
    for (int i = 0; i < n; i++) begin
      stepIn(1'b0, logic'(i & 1));
      check(prodBitsOut == '0 && !prodBitValid && !prodDone, "R8", "idle outputs",
            int'(prodBitsOut), 0);
    end
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(prodBitsOut == '0 && !prodBitValid && !prodDone, "R1", "in reset",
          int'(prodBitsOut), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    check(prodBitsOut == '0 && !prodBitValid && !prodDone, "R1", "after reset",
          int'(prodBitsOut), 0);
    idleCheck(3);

    // R3/R4/R7: full sweep, frames back to back, junk rotates on guard bits
    for (int a = -128; a < 128; a++) runFrame(a, (a + 128) % 4, L, "R3");

    idleCheck(4);

    // R4: extreme activations with hostile guard levels
    runFrame(-128, 1, L, "R4");
    runFrame(127, 1, L, "R4");
    runFrame(-1, 2, L, "R4");
    runFrame(0, 1, L, "R4");
    runFrame(127, 3, L, "R4");
    runFrame(-128, 2, L, "R4");

    // R6: abort mid-frame while carries are pending
    runFrame(-1, 0, 6, "R6");
    runFrame(55, 0, L, "R6");
    runFrame(-128, 0, 9, "R6");
    runFrame(-77, 1, L, "R6");
    runFrame(127, 0, L - 1, "R6");
    runFrame(-3, 2, L, "R6");

    // R7: explicit back-to-back pair following an idle gap
    idleCheck(2);
    runFrame(100, 0, L, "R7");
    runFrame(-100, 3, L, "R7");
    idleCheck(3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule